// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar entirely in packed binary coded decimal. It holds seconds, minutes, hours, a day-of-week counter, the date within the month, the month and a two-digit year, and advances them by one second each time the one-cycle `tick_i` enable is high. A ripple of carries moves the count from seconds up to the year. The date rolls over at the true end of each month. February gets a 29th day when the year is divisible by four, which is sufficient for the years 2000 to 2099.

Software or a bus bridge loads any single field through a one-cycle write port. The hour field is read and written in either 24-hour form or 12-hour form with an AM/PM flag, selected by `mode_12h_i`. After every accepted second increment the block raises `upd_o` for exactly one cycle, aligned with the new values, so that downstream alarm comparators sample only settled fields.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, day of week reads 1, date reads 0x01, month reads 0x01, year reads 0x00, and `upd_o` is low.
- R2: Each accepted tick adds one second in BCD (0x09 goes to 0x10). Seconds 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wraps to 0x00 and carries into hours.
- R3: With `mode_12h_i` low, the hour field is BCD 0x00 to 0x23 in bits 5:0. A carry from 0x23 gives 0x00 and advances the day.
- R4: With `mode_12h_i` high, hour bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. A carry at 11 gives 12 and toggles PM. A carry at 12 gives 01. A carry at PM 11 gives AM 12 and advances the day.
- R5: An advancing day rolls the date over to 0x01 after 0x30 in months 4, 6, 9 and 11, and after 0x31 in months 1, 3, 5, 7, 8, 10 and 12. It also carries into the month.
- R6: In month 2, the date rolls over after 0x29 when the BCD year is divisible by 4, and after 0x28 otherwise.
- R7: Month 0x12 rolls over to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R8: The 3-bit day of week counts 1 to 7. It advances on every day carry, and 7 wraps to 1, regardless of the date.
- R9: When `wr_en_i` is high, `wr_data_i` is masked to the field width and loaded into the field picked by `wr_sel_i`. The codes are 0 seconds (0x7F), 1 minutes (0x7F), 2 hours (0x3F), 3 day of week (0x07), 4 date (0x3F), 5 month (0x1F), 6 year (0xFF), and 7 selects nothing. A tick in the same cycle is dropped.
- R10: A write to any field other than seconds leaves the seconds value unchanged.
- R11: `upd_o` is high for exactly the one cycle in which the values from an accepted tick first appear, and is low otherwise.
- R12: With neither tick nor write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle one-second enable |
| mode_12h_i | input | 1 | 1 selects 12-hour format with PM flag |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select code (R9) |
| wr_data_i | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours (format per R3/R4) |
| dow_o | output | 3 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00..99, BCD |
| upd_o | output | 1 | One-cycle update strobe |

## Verification
The hardest cases to reach are the deep carry chains: a year rollover or a leap-day boundary would need millions of ticks from reset. The bench gets there by loading every field through the write port to one second before the boundary, such as PM 11:59:59 or 28 February of a leap and a non-leap year. It then issues a single tick and checks every field that the carry passes through.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int FIELD_W = 8;
    localparam int DOW_W   = 3;
    localparam int SEL_W   = 3;

    typedef logic [FIELD_W-1:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DOW   = 3'd3,
        SEL_DATE  = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_NONE  = 3'd7
    } fld_sel_e;

    localparam bcd_t MASK_SEC   = 8'h7F;
    localparam bcd_t MASK_MIN   = 8'h7F;
    localparam bcd_t MASK_HOUR  = 8'h3F;
    localparam bcd_t MASK_DATE  = 8'h3F;
    localparam bcd_t MASK_MONTH = 8'h1F;
    localparam bcd_t MASK_YEAR  = 8'hFF;

    typedef struct packed {
        bcd_t             sec;
        bcd_t             min;
        bcd_t             hour;
        logic [DOW_W-1:0] dow;
        bcd_t             date;
        bcd_t             month;
        bcd_t             year;
        logic             upd;
    } cal_state_t;

    // Add one to a two-digit packed BCD value
    function automatic bcd_t bcd_inc(input bcd_t v);
        bcd_t r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'h0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_wrap_inc.sv
module bcd_wrap_inc
    import bcd_cal_pkg::*;
#(
    parameter bcd_t FIRST = 8'h00
) (
    input  logic en_i,
    input  bcd_t val_i,
    input  bcd_t last_i,
    output bcd_t nxt_o,
    output logic carry_o
);
    logic at_end;

    always_comb begin
        at_end = (val_i >= last_i);
        if (!en_i) begin
            nxt_o = val_i;
        end else if (at_end) begin
            nxt_o = FIRST;
        end else begin
            nxt_o = bcd_inc(val_i);
        end
        carry_o = en_i && at_end;
    end
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
    import bcd_cal_pkg::*;
(
    input  bcd_t month_i,
    input  bcd_t year_i,
    output bcd_t last_o
);
    logic [1:0] mod4;
    logic       leap;

    always_comb begin
        // (10*tens + ones) mod 4 == (2*tens[0] + ones) mod 4
        mod4 = year_i[1:0] + {year_i[4], 1'b0};
        leap = (mod4 == 2'd0);
        unique case (month_i)
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_hour_step.sv
module bcd_hour_step
    import bcd_cal_pkg::*;
(
    input  logic en_i,
    input  logic mode_12h_i,
    input  bcd_t hour_i,
    output bcd_t nxt_o,
    output logic carry_o
);
    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;
    bcd_t       inc12;
    bcd_t       inc24;

    always_comb begin
        pm    = hour_i[5];
        h12   = hour_i[4:0];
        h24   = hour_i[5:0];
        inc12 = bcd_inc({3'b000, h12});
        inc24 = bcd_inc({2'b00, h24});
        nxt_o   = hour_i;
        carry_o = 1'b0;
        if (en_i) begin
            if (mode_12h_i) begin
                if (h12 == 5'h11) begin
                    nxt_o   = {2'b00, ~pm, 5'h12};
                    carry_o = pm;
                end else if (h12 >= 5'h12) begin
                    nxt_o = {2'b00, pm, 5'h01};
                end else begin
                    nxt_o = {2'b00, pm, inc12[4:0]};
                end
            end else begin
                if (h24 >= 6'h23) begin
                    nxt_o   = 8'h00;
                    carry_o = 1'b1;
                end else begin
                    nxt_o = {2'b00, inc24[5:0]};
                end
            end
        end
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import bcd_cal_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             mode_12h_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       sec_o,
    output logic [7:0]       min_o,
    output logic [7:0]       hour_o,
    output logic [DOW_W-1:0] dow_o,
    output logic [7:0]       date_o,
    output logic [7:0]       month_o,
    output logic [7:0]       year_o,
    output logic             upd_o
);
    localparam logic [DOW_W-1:0] DOW_FIRST = 3'd1;
    localparam logic [DOW_W-1:0] DOW_LAST  = 3'd7;
    localparam cal_state_t RESET_STATE = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: DOW_FIRST,
        date: 8'h01, month: 8'h01, year: 8'h00, upd: 1'b0};

    cal_state_t state_d, state_q;

    bcd_t sec_n, min_n, hour_n, date_n, month_n, year_n, date_last;
    logic c_sec, c_min, c_day, c_date, c_month, c_year_unused;
    logic [DOW_W-1:0] dow_n;

    bcd_wrap_inc #(.FIRST(8'h00)) u_sec (
        .en_i(1'b1), .val_i(state_q.sec), .last_i(8'h59),
        .nxt_o(sec_n), .carry_o(c_sec));

    bcd_wrap_inc #(.FIRST(8'h00)) u_min (
        .en_i(c_sec), .val_i(state_q.min), .last_i(8'h59),
        .nxt_o(min_n), .carry_o(c_min));

    bcd_hour_step u_hour (
        .en_i(c_min), .mode_12h_i(mode_12h_i), .hour_i(state_q.hour),
        .nxt_o(hour_n), .carry_o(c_day));

    bcd_month_len u_mlen (
        .month_i(state_q.month), .year_i(state_q.year), .last_o(date_last));

    bcd_wrap_inc #(.FIRST(8'h01)) u_date (
        .en_i(c_day), .val_i(state_q.date), .last_i(date_last),
        .nxt_o(date_n), .carry_o(c_date));

    bcd_wrap_inc #(.FIRST(8'h01)) u_month (
        .en_i(c_date), .val_i(state_q.month), .last_i(8'h12),
        .nxt_o(month_n), .carry_o(c_month));

    bcd_wrap_inc #(.FIRST(8'h00)) u_year (
        .en_i(c_month), .val_i(state_q.year), .last_i(8'h99),
        .nxt_o(year_n), .carry_o(c_year_unused));

    // Day of week runs on the day carry, independent of the date
    always_comb begin
        if (!c_day) begin
            dow_n = state_q.dow;
        end else if (state_q.dow >= DOW_LAST) begin
            dow_n = DOW_FIRST;
        end else begin
            dow_n = state_q.dow + 3'd1;
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.upd = 1'b0;
        if (wr_en_i) begin
            unique case (fld_sel_e'(wr_sel_i))
                SEL_SEC:   state_d.sec   = wr_data_i & MASK_SEC;
                SEL_MIN:   state_d.min   = wr_data_i & MASK_MIN;
                SEL_HOUR:  state_d.hour  = wr_data_i & MASK_HOUR;
                SEL_DOW:   state_d.dow   = wr_data_i[DOW_W-1:0];
                SEL_DATE:  state_d.date  = wr_data_i & MASK_DATE;
                SEL_MONTH: state_d.month = wr_data_i & MASK_MONTH;
                SEL_YEAR:  state_d.year  = wr_data_i & MASK_YEAR;
                default:   ;
            endcase
        end else if (tick_i) begin
            state_d.sec   = sec_n;
            state_d.min   = min_n;
            state_d.hour  = hour_n;
            state_d.dow   = dow_n;
            state_d.date  = date_n;
            state_d.month = month_n;
            state_d.year  = year_n;
            state_d.upd   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o   = state_q.sec;
    assign min_o   = state_q.min;
    assign hour_o  = state_q.hour;
    assign dow_o   = state_q.dow;
    assign date_o  = state_q.date;
    assign month_o = state_q.month;
    assign year_o  = state_q.year;
    assign upd_o   = state_q.upd;

endmodule

// File: rtl/bcd_calendar_clock_chk.sv
module bcd_calendar_clock_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic       upd_o
);
    // R11
    strobe_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && !wr_en_i |=> upd_o);

    // R9
    write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> !upd_o);

    // R12
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i && !wr_en_i |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));

    // R9
    sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && wr_sel_i == 3'd0 |=> sec_o == ($past(wr_data_i) & 8'h7F));

    // R10
    sec_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && wr_sel_i != 3'd0 |=> $stable(sec_o));

    // R2
    sec_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && !wr_en_i && sec_o <= 8'h59 |=> sec_o != $past(sec_o) && sec_o <= 8'h59);
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk u_chk (.*);

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode12 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec, min, hour, date, month, year;
    logic [2:0] dow;
    logic       upd;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    bcd_calendar_clock u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_12h_i(mode12),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow),
        .date_o(date), .month_o(month), .year_o(year), .upd_o(upd));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic load(input logic [7:0] y, mo, d, input logic [2:0] w,
                        input logic [7:0] h, mi, s);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, {5'b0, w});
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic t_reset();
        chk("R1 sec", sec, 8'h00);   chk("R1 min", min, 8'h00);
        chk("R1 hour", hour, 8'h00); chk("R1 dow", {5'b0, dow}, 8'h01);
        chk("R1 date", date, 8'h01); chk("R1 month", month, 8'h01);
        chk("R1 year", year, 8'h00); chk("R1 upd", {7'b0, upd}, 8'h00);
    endtask

    task automatic t_seconds();
        load(8'h21, 8'h06, 8'h15, 3'd3, 8'h10, 8'h20, 8'h09);
        one_tick();
        chk("R2 09->10", sec, 8'h10);
        chk("R11 strobe high", {7'b0, upd}, 8'h01);
        @(negedge clk);
        chk("R11 strobe one cycle", {7'b0, upd}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R12 hold", sec, 8'h10);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59);
        one_tick();
        chk("R2 sec wrap", sec, 8'h00); chk("R2 min wrap", min, 8'h00);
        chk("R2 hour carry", hour, 8'h11);
    endtask

    task automatic t_24h();
        mode12 = 1'b0;
        load(8'h21, 8'h06, 8'h15, 3'd3, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R3 hour", hour, 8'h00); chk("R3 date", date, 8'h16);
        chk("R8 dow", {5'b0, dow}, 8'h04); chk("R3 month", month, 8'h06);
    endtask

    task automatic t_12h();
        mode12 = 1'b1;
        load(8'h21, 8'h06, 8'h15, 3'd7, 8'h11, 8'h59, 8'h59);
        one_tick();
        chk("R4 AM11->PM12", hour, 8'h32); chk("R4 no day", date, 8'h15);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        one_tick();
        chk("R4 PM12->PM01", hour, 8'h21);
        load(8'h21, 8'h06, 8'h15, 3'd7, 8'h31, 8'h59, 8'h59);
        one_tick();
        chk("R4 PM11->AM12", hour, 8'h12); chk("R4 day carry", date, 8'h16);
        chk("R8 dow 7->1", {5'b0, dow}, 8'h01);
        mode12 = 1'b0;
    endtask

    task automatic t_months();
        load(8'h21, 8'h04, 8'h30, 3'd2, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R5 30-day date", date, 8'h01); chk("R5 30-day month", month, 8'h05);
        load(8'h21, 8'h07, 8'h30, 3'd2, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R5 31-day date", date, 8'h31);
        load(8'h23, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R6 nonleap date", date, 8'h01); chk("R6 nonleap month", month, 8'h03);
        load(8'h24, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R6 leap 29", date, 8'h29); chk("R6 leap month", month, 8'h02);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        one_tick();
        chk("R6 leap end", date, 8'h01); chk("R6 leap end month", month, 8'h03);
        load(8'h12, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R6 year 12 leap", date, 8'h29);
    endtask

    task automatic t_year();
        load(8'h99, 8'h12, 8'h31, 3'd5, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R7 month", month, 8'h01); chk("R7 year", year, 8'h00);
        chk("R7 date", date, 8'h01);
        load(8'h45, 8'h12, 8'h31, 3'd5, 8'h23, 8'h59, 8'h59);
        one_tick();
        chk("R7 year inc", year, 8'h46);
    endtask

    task automatic t_write();
        load(8'h30, 8'h03, 8'h10, 3'd1, 8'h08, 8'h15, 8'h42);
        chk("R10 sec kept", sec, 8'h42);
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        chk("R9 write loaded", min, 8'h33);
        chk("R9 tick dropped", sec, 8'h42);
        chk("R9 no strobe", {7'b0, upd}, 8'h00);
        wr(3'd2, 8'hFF);
        chk("R9 hour mask", hour, 8'h3F);
        wr(3'd5, 8'hF2);
        chk("R9 month mask", month, 8'h12);
        wr(3'd3, 8'hFE);
        chk("R9 dow mask", {5'b0, dow}, 8'h06);
        wr(3'd7, 8'h00);
        chk("R9 no-select", year, 8'h30);
        chk("R10 sec after writes", sec, 8'h42);
        wr(3'd0, 8'hD5);
        chk("R9 sec mask", sec, 8'h55);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_24h();
        t_12h();
        t_months();
        t_year();
        t_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule